// File: doc/BRIEF.md
# Two-Wire Target Port for a 16-bit Register Bank

This block lets an external two-wire (I2C) controller read and write a bank of 16-bit registers. It sits on the system clock and oversamples the SCL and SDA lines. It finds start and stop conditions, answers one fixed 7-bit device address, and takes an 8-bit register index. It then moves register words as a high byte followed by a low byte. It drives SDA only through an open-drain enable and never holds SCL low.

A write carries the device address with R/W low, the index, and then any number of words. Each complete word turns into a single-cycle write strobe, and the index moves on after every word. A read first sets the index with a write, then issues a repeated start and the address with R/W high. The block then returns words from successive indices until the controller declines to acknowledge a byte. Read data comes from the bank through a one-cycle request. The bank must present the data by the cycle after the request.

Top module: `i2c16_target`

## Requirements
- R1: The block changes its SDA drive only after a falling SCL edge, and it samples SDA on rising SCL edges. Its drive level stays constant while SCL is high.
- R2: The first byte after a start is taken MSB first. Its upper seven bits must equal 0,1,1,X,1,1,1, where X is the parameter `ADDR_X`. Its lowest bit is R/W, with 1 meaning read. On a match the block pulls SDA low for the ninth clock.
- R3: On an address mismatch the block gives no acknowledge. It keeps SDA released and ignores all bytes until the next start condition.
- R4: In a write frame the byte after the address is the register index. The block acknowledges it and uses it as the access pointer.
- R5: Data bytes arrive high byte first. After the low byte, the block asserts `wr_en` for one cycle with `wr_addr` set to the pointer and `wr_data` set to {high, low}. It acknowledges every data byte.
- R6: After each completed word the pointer advances by one. It wraps from 0xFF to 0x00.
- R7: A stop or start that arrives after only the high byte of a word discards that byte. No write strobe follows.
- R8: After a repeated start with R/W=1, the block returns the word at the pointer, high byte first, MSB first. While the controller acknowledges, it continues with the next index. After a byte that is not acknowledged, it releases SDA until the next start.
- R9: For each word it sends, the block asserts `rd_req` for one cycle with the index on `rd_addr`. It samples `rd_data` in the following cycle. One more word is fetched ahead when the low byte of a word starts, so a read of n words makes n+1 requests.
- R10: After reset, SDA is released and neither `wr_en` nor `rd_req` is active.
- R11: `wr_en` and `rd_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | IDX_W | Register index of the write |
| wr_data | output | DATA_W | Word to write |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | IDX_W | Register index being read |
| rd_data | input | DATA_W | Word from the bank, valid the cycle after `rd_req` |

## Verification
The falling SCL edge that ends a low data byte does two things in the same cycle: it commits the word to the bank and raises the acknowledge drive. The same edge that launches a low read byte also advances the pointer and issues the look-ahead fetch. The bench provokes both with bursts that cross index 0xFF and with random multi-word bursts. It judges them by the acknowledge seen on the bus, the count of write strobes and read requests per frame, and readback of every word through a later read frame.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_RX,
      LS_RX_ACK,
      LS_TX,
      LS_TX_ACK,
      LS_IGNORE
   } link_state_t;

   typedef enum logic [1:0] {
      RB_DEVICE,
      RB_INDEX,
      RB_DATA
   } rx_byte_t;

   function automatic logic [6:0] dev_pattern(input logic xbit);
      return {3'b011, xbit, 3'b111};
   endfunction

endpackage

// File: rtl/i2c16_line_sync.sv
module i2c16_line_sync #(
   parameter int STAGES = 2,
   parameter bit FILTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c16_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_p, sda_p;
   logic scl_f, sda_f, scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
      end else begin
         scl_p <= {scl_p[STAGES-2:0], scl_i};
         sda_p <= {sda_p[STAGES-2:0], sda_i};
      end
   end

   if (FILTER) begin : g_filter
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_f <= 1'b1;
            sda_f <= 1'b1;
         end else begin
            if (scl_p[STAGES-1] == scl_p[STAGES-2]) scl_f <= scl_p[STAGES-1];
            if (sda_p[STAGES-1] == sda_p[STAGES-2]) sda_f <= sda_p[STAGES-1];
         end
      end
   end else begin : g_plain
      assign scl_f = scl_p[STAGES-1];
      assign sda_f = sda_p[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_s     = scl_f;
   assign sda_s     = sda_f;
   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c16_link.sv
module i2c16_link
   import i2c16_pkg::*;
#(
   parameter int         IDX_W    = 8,
   parameter int         DATA_W   = 16,
   parameter logic [6:0] DEV_ADDR = 7'h37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   output logic [IDX_W-1:0]  rd_addr,
   input  logic [DATA_W-1:0] rd_data
);

   localparam int NB = DATA_W / 8;
   localparam int BW = (NB > 2) ? $clog2(NB) : 1;
   localparam logic [BW-1:0] LAST = BW'(NB - 1);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("i2c16_link: DATA_W must be a multiple of 8 and at least 16");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("i2c16_link: IDX_W must lie in 1..8");
   end

   link_state_t       state;
   rx_byte_t          role;
   logic [3:0]        cnt;
   logic [7:0]        shreg, txsh;
   logic              rw, nack, rd_q;
   logic [IDX_W-1:0]  ptr;
   logic [DATA_W-1:0] acc, hold;
   logic [BW-1:0]     bsel, nb;
   logic [7:0]        nb_byte;

   assign nb      = (bsel == LAST) ? '0 : bsel + 1'b1;
   assign nb_byte = hold[(DATA_W-1) - 8*int'(nb) -: 8];
   assign rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LS_IDLE;
         role    <= RB_DEVICE;
         cnt     <= '0;
         shreg   <= '0;
         txsh    <= '0;
         rw      <= 1'b0;
         nack    <= 1'b1;
         rd_q    <= 1'b0;
         ptr     <= '0;
         acc     <= '0;
         hold    <= '0;
         bsel    <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         rd_req  <= 1'b0;
      end else begin
         wr_en  <= 1'b0;
         rd_req <= 1'b0;
         rd_q   <= rd_req;
         if (rd_q) hold <= rd_data;
         if (start_det) begin
            state  <= LS_RX;
            role   <= RB_DEVICE;
            cnt    <= '0;
            bsel   <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= LS_IDLE;
            bsel   <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               LS_RX: begin
                  if (scl_rise && cnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (role == RB_DEVICE) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           rd_req <= shreg[0];
                           state  <= LS_RX_ACK;
                        end else begin
                           state <= LS_IGNORE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        state  <= LS_RX_ACK;
                        if (role == RB_INDEX) begin
                           ptr  <= shreg[IDX_W-1:0];
                           bsel <= '0;
                        end else if (bsel == LAST) begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= {acc[DATA_W-9:0], shreg};
                           ptr     <= ptr + 1'b1;
                           bsel    <= '0;
                        end else begin
                           acc  <= {acc[DATA_W-9:0], shreg};
                           bsel <= bsel + 1'b1;
                        end
                     end
                  end
               end
               LS_RX_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (role == RB_DEVICE && rw) begin
                        state  <= LS_TX;
                        bsel   <= '0;
                        txsh   <= hold[DATA_W-1 -: 8];
                        sda_oe <= ~hold[DATA_W-1];
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= LS_RX;
                        role   <= (role == RB_DEVICE) ? RB_INDEX : RB_DATA;
                     end
                  end
               end
               LS_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= LS_TX_ACK;
                     end else begin
                        sda_oe <= ~txsh[6];
                        txsh   <= {txsh[6:0], 1'b0};
                     end
                  end
               end
               LS_TX_ACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        state <= LS_IGNORE;
                     end else begin
                        state  <= LS_TX;
                        bsel   <= nb;
                        txsh   <= nb_byte;
                        sda_oe <= ~nb_byte[7];
                        if (nb == LAST) begin
                           ptr    <= ptr + 1'b1;
                           rd_req <= 1'b1;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_drive_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_s))
      else $error("p_drive_on_low_r1");

   p_released_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_IGNORE || state == LS_IDLE) |-> !sda_oe)
      else $error("p_released_idle_r3");

   p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en)
      else $error("p_write_pulse_r5");

   p_read_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req)
      else $error("p_read_pulse_r9");

   p_no_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_req))
      else $error("p_no_collide_r11");

endmodule

// File: rtl/i2c16_target.sv
module i2c16_target #(
   parameter int ADDR_X        = 0,
   parameter int IDX_W         = 8,
   parameter int DATA_W        = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit GLITCH_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   output logic [IDX_W-1:0]  rd_addr,
   input  logic [DATA_W-1:0] rd_data
);

   if (ADDR_X < 0 || ADDR_X > 1) begin : g_bad_x
      $error("i2c16_target: ADDR_X must be 0 or 1");
   end

   localparam logic [6:0] DEV_ADDR = i2c16_pkg::dev_pattern(ADDR_X[0]);

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c16_line_sync #(
      .STAGES (SYNC_STAGES),
      .FILTER (GLITCH_FILTER)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c16_link #(
      .IDX_W    (IDX_W),
      .DATA_W   (DATA_W),
      .DEV_ADDR (DEV_ADDR)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

endmodule

// File: tb/i2c16_target_tb_top.sv
module i2c16_target_tb_top;

   localparam int Q      = 5;
   localparam int WD_CYC = 190000;
   localparam bit XBIT   = 1'b0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic scl = 1'b1;
   logic sda_drv_low = 1'b0;
   logic sda_oe, wr_en, rd_req;
   logic [7:0] wr_addr, rd_addr;
   logic [15:0] wr_data, rd_data;
   wire sda_line = ~(sda_drv_low | sda_oe);

   i2c16_target #(.ADDR_X(0)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl),
      .sda_i   (sda_line),
      .sda_oe  (sda_oe),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_req  (rd_req),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   function automatic logic [15:0] seed_val(input int i);
      return 16'(i * 16'h0101) ^ 16'h5A3C;
   endfunction

   function automatic logic [7:0] dev_byte(input logic xb, input logic rw);
      return {3'b011, xb, 3'b111, rw};
   endfunction

   logic [15:0] bank [256];
   logic [15:0] expv [256];
   logic [15:0] wbuf [8];
   int wr_seen = 0, rd_seen = 0, collide = 0, r1_bad = 0, oe_seen = 0;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bank[i] <= seed_val(i);
      end else if (wr_en) begin
         bank[wr_addr] <= wr_data;
      end
   end
   assign rd_data = bank[rd_addr];

   always @(posedge clk) begin
      if (rst_n) begin
         if (wr_en) wr_seen++;
         if (rd_req) rd_seen++;
         if (wr_en && rd_req) collide++;
         if (sda_oe) oe_seen++;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv_low = 1'b0; waitq();
      scl = 1'b1; waitq();
      sda_drv_low = 1'b1; waitq();
      scl = 1'b0; waitq();
   endtask

   task automatic bus_stop();
      waitq(); sda_drv_low = 1'b1; waitq();
      scl = 1'b1; waitq();
      sda_drv_low = 1'b0; waitq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic a_end;
      for (int i = 7; i >= 0; i--) begin
         waitq(); sda_drv_low = ~b[i];
         waitq(); scl = 1'b1;
         waitq(); waitq(); scl = 1'b0;
      end
      waitq(); sda_drv_low = 1'b0;
      waitq(); scl = 1'b1;
      waitq(); ack = ~sda_line;
      waitq(); a_end = ~sda_line;
      if (a_end != ack) r1_bad++;
      scl = 1'b0;
   endtask

   task automatic recv_byte(input logic do_ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         waitq(); waitq(); scl = 1'b1;
         waitq(); d[i] = sda_line;
         waitq();
         if (sda_line != d[i]) r1_bad++;
         scl = 1'b0;
      end
      waitq(); sda_drv_low = do_ack;
      waitq(); scl = 1'b1;
      waitq(); waitq(); scl = 1'b0;
      waitq(); sda_drv_low = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] idx, input int n);
      logic a;
      int w0;
      logic [7:0] j;
      w0 = wr_seen;
      bus_start();
      send_byte(dev_byte(XBIT, 1'b0), a);
      chk(a, "R2 address ack", a, 1);
      send_byte(idx, a);
      chk(a, "R4 index ack", a, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k][15:8], a);
         send_byte(wbuf[k][7:0], a);
         chk(a, "R5 data ack", a, 1);
         j = idx + 8'(k);
         expv[j] = wbuf[k];
      end
      bus_stop();
      chk(wr_seen - w0 == n, "R5 strobe count", wr_seen - w0, n);
   endtask

   task automatic do_read(input logic [7:0] idx, input int n);
      logic a;
      logic [7:0] hi, lo, j;
      int r0;
      bus_start();
      send_byte(dev_byte(XBIT, 1'b0), a);
      send_byte(idx, a);
      r0 = rd_seen;
      bus_start();
      send_byte(dev_byte(XBIT, 1'b1), a);
      chk(a, "R2 read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(1'b1, hi);
         recv_byte(k < n - 1, lo);
         j = idx + 8'(k);
         chk({hi, lo} == expv[j], "R8 R6 read word", {hi, lo}, expv[j]);
      end
      chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
      bus_stop();
      chk(rd_seen - r0 == n + 1, "R9 request count", rd_seen - r0, n + 1);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] ix;
      int n, w0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) expv[i] = seed_val(i);
      repeat (5) @(negedge clk);
      // R10: reset state
      chk(sda_oe == 0, "R10 sda released in reset", sda_oe, 0);
      chk(wr_en == 0 && rd_req == 0, "R10 strobes idle in reset", {wr_en, rd_req}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 0, "R10 sda released after reset", sda_oe, 0);

      // R5 single word, then readback
      wbuf[0] = 16'hBEEF;
      do_write(8'h10, 1);
      do_read(8'h10, 1);

      // R6 burst write with increment
      wbuf[0] = 16'h1234; wbuf[1] = 16'hA5F0; wbuf[2] = 16'h0F0F;
      do_write(8'h20, 3);
      do_read(8'h20, 3);

      // R6 wrap from 0xFF to 0x00
      wbuf[0] = 16'hFACE; wbuf[1] = 16'hC0DE;
      do_write(8'hFF, 2);
      do_read(8'hFF, 2);

      // R7 high byte then stop is discarded
      w0 = wr_seen;
      bus_start();
      send_byte(dev_byte(XBIT, 1'b0), a);
      send_byte(8'h30, a);
      send_byte(8'h99, a);
      bus_stop();
      chk(wr_seen == w0, "R7 no strobe on half word", wr_seen - w0, 0);
      do_read(8'h30, 1);

      // R7 high byte then repeated start is discarded
      w0 = wr_seen;
      bus_start();
      send_byte(dev_byte(XBIT, 1'b0), a);
      send_byte(8'h31, a);
      send_byte(8'h77, a);
      bus_start();
      send_byte(dev_byte(XBIT, 1'b0), a);
      send_byte(8'h32, a);
      bus_stop();
      chk(wr_seen == w0, "R7 no strobe across restart", wr_seen - w0, 0);
      do_read(8'h31, 2);

      // R3 address mismatch (other X value)
      oe_seen = 0;
      w0 = wr_seen;
      bus_start();
      send_byte(dev_byte(~XBIT, 1'b0), a);
      chk(a == 1'b0, "R3 no ack on mismatch", a, 0);
      send_byte(8'h40, a);
      chk(a == 1'b0, "R3 later byte ignored", a, 0);
      send_byte(8'h00, a);
      send_byte(8'h11, a);
      bus_stop();
      chk(oe_seen == 0 && wr_seen == w0, "R3 bus untouched", oe_seen, 0);
      do_read(8'h40, 1);

      // random bursts
      for (int it = 0; it < 10; it++) begin
         ix = 8'($urandom);
         n = 1 + int'($urandom % 4);
         for (int k = 0; k < n; k++) wbuf[k] = 16'($urandom);
         do_write(ix, n);
         do_read(ix, n);
      end

      chk(r1_bad == 0, "R1 drive stable while SCL high", r1_bad, 0);
      chk(collide == 0, "R11 write and read strobes apart", collide, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule